// File: doc/BRIEF.md
# Manchester Serial Encoder

This block turns a stream of bytes into a single Manchester-coded line signal. Bytes come in over a valid/ready handshake. The block runs from a clock at twice the bit rate, so every bit occupies two consecutive clock cycles, called half-bit slots. Each bit is sent as a transition of fixed direction at the middle of its bit time. A 1 is high then low. A 0 is low then high. A transition at the boundary between two bit times appears only when the two bits are equal.

Each frame opens with a preamble of encoded 1 bits, so that a far-end receiver can lock its recovered clock onto the line before the data arrives. The preamble length is set by a parameter. Bytes then follow with the least significant bit first. A new byte can be handed over during the final half-bit slot of the current byte, and it then follows with no gap and no new preamble. If no byte is offered in that slot, the frame closes and the line returns to a low idle level. A separate enable output marks the cycles during which a frame is on the line.

Top module: `manchester_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_out` is 0, `line_en` is 0 and `in_ready` is 1.
- R2: A data bit of value 1 drives `line_out` high in its first slot and low in its second slot. A data bit of value 0 drives low then high. Each bit takes exactly two clock cycles.
- R3: In every bit time of a frame, the second slot carries the inverse of the first slot, which gives a transition at mid-bit.
- R4: The cycle after an idle handshake (`in_valid` and `in_ready` both high) starts a preamble of `PRE_BITS` encoded 1 bits. The line pattern is 1,0 repeated `PRE_BITS` times (default 8).
- R5: After the preamble, each byte is sent with bit 0 first and bit 7 last.
- R6: During a frame, `in_ready` is 1 only in the second slot of bit 7 of the current byte. A handshake in that slot sends the new byte's bit 0 from the next cycle, with no gap and no preamble.
- R7: If `in_valid` is 0 in that final slot, the frame ends. From the next cycle `line_en` and `line_out` are 0 and `in_ready` is 1, and the next frame starts again with a full preamble.
- R8: `line_en` is 1 from the first preamble slot through the last data slot of the frame, and 0 otherwise.
- R9: The byte is captured at the handshake. Changes on `in_data` while that byte is being sent have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate; one cycle per half-bit slot |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_data | input | DATA_W | Byte to send, least significant bit first |
| in_ready | output | 1 | Byte is accepted when this and `in_valid` are both high |
| line_out | output | 1 | Manchester-coded serial line |
| line_en | output | 1 | High while a frame, including its preamble, is on the line |

## Verification
On every cycle the assertions check four things. A mid-bit transition follows every first slot. The line is low whenever the enable is low. A frame always opens on a high slot. The handshake in the final slot decides whether the enable stays high or drops. Only the bench's scenarios can show the rest, because it depends on which byte was offered and when: the preamble length, the bit order and values, the recovered bytes, and that changes on `in_data` mid-byte leave the line alone. The bench decodes the line slot by slot across all 256 byte values, in single-byte and multi-byte frames.

// File: rtl/mancenc_pkg.sv
package mancenc_pkg;
  // Sequencer phase: no frame, preamble slots, or data slots.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } tx_state_e;
endpackage

// File: rtl/mancenc_seq.sv
module mancenc_seq
  import mancenc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_BITS = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  output tx_state_e state_o,
  output logic      half_o,
  output logic      load_o,
  output logic      shift_o,
  output logic      ready_o
);
  localparam int CNT_MAX = (DATA_W > PRE_BITS) ? DATA_W : PRE_BITS;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'((PRE_BITS > 0) ? PRE_BITS - 1 : 0);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             half_q, half_d;
  logic             load, shift, ready;
  tx_state_e        start_state;

  // A zero-length preamble goes straight to data.
  generate
    if (PRE_BITS == 0) begin : g_no_pre
      assign start_state = ST_DATA;
    end else begin : g_pre
      assign start_state = ST_PRE;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    half_d  = half_q;
    load    = 1'b0;
    shift   = 1'b0;
    ready   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        ready = 1'b1;
        if (in_valid) begin
          load    = 1'b1;
          bit_d   = '0;
          half_d  = 1'b0;
          state_d = start_state;
        end
      end
      ST_PRE: begin
        half_d = ~half_q;
        if (half_q) begin
          if (bit_q == PRE_LAST) begin
            state_d = ST_DATA;
            bit_d   = '0;
          end else begin
            bit_d = bit_q + CNT_W'(1);
          end
        end
      end
      ST_DATA: begin
        half_d = ~half_q;
        if (half_q) begin
          if (bit_q == DATA_LAST) begin
            ready = 1'b1;
            bit_d = '0;
            if (in_valid) begin
              load = 1'b1;
            end else begin
              state_d = ST_IDLE;
              half_d  = 1'b0;
            end
          end else begin
            shift = 1'b1;
            bit_d = bit_q + CNT_W'(1);
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        bit_d   = '0;
        half_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      half_q  <= half_d;
    end
  end

  assign state_o = state_q;
  assign half_o  = half_q;
  assign load_o  = load;
  assign shift_o = shift;
  assign ready_o = ready;
endmodule

// File: rtl/mancenc_shift.sv
module mancenc_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data_in,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = data_in;
    end else if (shift) begin
      sh_d = sh_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load || shift) begin
      sh_q <= sh_d;
    end
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/mancenc_line.sv
module mancenc_line
  import mancenc_pkg::*;
(
  input  tx_state_e state,
  input  logic      half,
  input  logic      data_bit,
  output logic      line,
  output logic      en
);
  logic active;
  logic slot_bit;

  always_comb begin
    active   = 1'b0;
    slot_bit = 1'b0;
    case (state)
      ST_PRE:  begin active = 1'b1; slot_bit = 1'b1;     end
      ST_DATA: begin active = 1'b1; slot_bit = data_bit; end
      default: begin active = 1'b0; slot_bit = 1'b0;     end
    endcase
  end

  // The first slot carries the bit value, the second slot its inverse.
  assign line = active & (slot_bit ^ half);
  assign en   = active;
endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import mancenc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              line_out,
  output logic              line_en
);
  tx_state_e tx_state;
  logic      tx_half;
  logic      tx_load;
  logic      tx_shift;
  logic      tx_bit;

  mancenc_seq #(.DATA_W(DATA_W), .PRE_BITS(PRE_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .state_o  (tx_state),
    .half_o   (tx_half),
    .load_o   (tx_load),
    .shift_o  (tx_shift),
    .ready_o  (in_ready)
  );

  mancenc_shift #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tx_load),
    .shift   (tx_shift),
    .data_in (in_data),
    .bit_o   (tx_bit)
  );

  mancenc_line u_line (
    .state    (tx_state),
    .half     (tx_half),
    .data_bit (tx_bit),
    .line     (line_out),
    .en       (line_en)
  );
endmodule

// File: rtl/manchester_tx_chk.sv
module manchester_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic line_out,
  input logic line_en,
  input logic half
);
  // R1: no frame means a low line and an open input.
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |-> (!line_out && in_ready));

  // R3: a first slot is always followed by the opposite level.
  a_r3_mid_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && !half) |=> (line_out != $past(line_out)));

  // R4: a frame opens with the high slot of an encoded 1.
  a_r4_frame_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_en) |-> line_out);

  // R6: within a frame, ready appears only in a second slot.
  a_r6_ready_second_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && in_ready) |-> half);

  // R6: an accepted byte keeps the frame going with no gap.
  a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && in_ready && in_valid) |=> line_en);

  // R7: no byte offered in the final slot closes the frame.
  a_r7_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && in_ready && !in_valid) |=> !line_en);

  // R8: a frame always ends after a complete bit time.
  a_r8_whole_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_en) |-> $past(half));
endmodule

bind manchester_tx manchester_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .line_out (line_out),
  .line_en  (line_en),
  .half     (tx_half)
);

// File: tb/manchester_tx_tb.sv
module manchester_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PRE        = 8;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       line_out;
  logic       line_en;

  int checks = 0;
  int fails  = 0;
  logic [7:0] msg [0:255];

  manchester_tx #(.DATA_W(8), .PRE_BITS(PRE)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .line_out (line_out),
    .line_en  (line_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_check(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      chk("R1 idle line", line_out, 0);
      chk("R1 idle enable", line_en, 0);
      chk("R1 idle ready", in_ready, 1);
      @(negedge clk);
    end
  endtask

  // Sends msg[0..n-1] as one frame and decodes the line slot by slot.
  task automatic send_frame(input int n, input bit scramble);
    logic [7:0] got;
    logic       first;
    chk("R1 ready before frame", in_ready, 1);
    chk("R8 enable before frame", line_en, 0);
    in_valid = 1'b1;
    in_data  = msg[0];
    @(negedge clk);
    in_valid = 1'b0;
    if (scramble) in_data = ~msg[0];
    for (int p = 0; p < PRE; p++) begin
      chk("R4 preamble first slot", line_out, 1);
      chk("R8 enable in preamble", line_en, 1);
      chk("R6 ready low in preamble", in_ready, 0);
      @(negedge clk);
      chk("R4 preamble second slot", line_out, 0);
      @(negedge clk);
    end
    for (int k = 0; k < n; k++) begin
      got = '0;
      for (int i = 0; i < 8; i++) begin
        first  = line_out;
        got[i] = first;
        chk("R2 first slot equals bit", first, msg[k][i]);
        chk("R8 enable in data", line_en, 1);
        chk("R6 ready low in first slot", in_ready, 0);
        @(negedge clk);
        chk("R3 second slot inverse", line_out, !first);
        if (i == 7) begin
          chk("R6 ready in final slot", in_ready, 1);
          if (k < n - 1) begin
            in_valid = 1'b1;
            in_data  = msg[k+1];
          end
        end else begin
          chk("R6 ready low mid byte", in_ready, 0);
        end
        @(negedge clk);
        if (i == 7 && k < n - 1) begin
          in_valid = 1'b0;
          if (scramble) in_data = ~msg[k+1];
        end
      end
      chk(scramble ? "R9 byte held despite input change" : "R5 recovered byte",
          got, msg[k]);
    end
    chk("R7 line low after frame", line_out, 0);
    chk("R7 enable low after frame", line_en, 0);
    chk("R7 ready after frame", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset line", line_out, 0);
    chk("R1 reset enable", line_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check(4);

    msg[0] = 8'hA5;
    send_frame(1, 1'b0);
    idle_check(3);

    for (int k = 0; k < 256; k++) msg[k] = 8'(k);
    send_frame(256, 1'b0);
    idle_check(2);

    msg[0] = 8'h00; msg[1] = 8'hFF; msg[2] = 8'h5A;
    send_frame(3, 1'b1);

    msg[0] = 8'h80; msg[1] = 8'h01;
    send_frame(2, 1'b1);
    idle_check(5);

    for (int k = 0; k < 256; k++) msg[k] = 8'(255 - k);
    send_frame(256, 1'b1);
    idle_check(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule